// File: doc/BRIEF.md
# I/O Page Table Translator

This block turns device-side virtual addresses into physical addresses. It uses a flat, single-level table of 32-bit entries, one entry per 4 KB page, that sits in external memory. A request carries a start address, a byte count and a direction. The translator reads the entry for the page that holds the current address through a fetch port. It checks the entry's valid and writable flags and then emits one physical access covering the part of the request that falls inside that page. It repeats this page by page until the byte count is used up.

There is no entry cache, so every page costs a fresh fetch. When an entry is unusable, the rest of the request is dropped and a one-cycle fault report gives the reason and the virtual address where the walk stopped. A control input can switch translation off. In that case the request is passed through as one access at its own address.

Top module: `iopt_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `pte_req_valid`, `acc_valid` and `fault_valid` are 0.
- R2: The entry for the current virtual address V is fetched from `(tbl_base << 4) + ((V - win_start) >> 10)`, with the sum's two low bits forced to zero (modulo 2^32).
- R3: A translated access address has bit 31 = 0, bits [30:12] = entry bits [26:8] and bits [11:0] = V[11:0]. All other entry bits have no effect on the address.
- R4: Each translated piece has length min(4096 - V[11:0], bytes left). The next piece starts at V + length, and `acc_last` is 1 only on the final piece.
- R5: Every translated piece is preceded by its own fetch. The number of fetches equals the number of pieces, plus one if the walk faults.
- R6: If entry bit 1 (valid) is 0, no access is made for that page or any later page. `fault_valid` then pulses for exactly one cycle with `fault_cause` = 2'b01 and `fault_vaddr` = V.
- R7: A write request whose entry has bit 2 (writable) = 0 makes no access for that page or later pages and reports `fault_cause` = 2'b10. A read request ignores bit 2.
- R8: When an entry is both invalid and read-only on a write, the cause reported is 2'b01.
- R9: If `xlat_en` is 0 when a request is accepted, one access is issued with `acc_paddr` = the request address and `acc_len` = the full length, with `acc_last` = 1 and `acc_cache` = 0. No fetch is made.
- R10: `acc_cache` equals entry bit 7 of the page being accessed, and `acc_write` equals the request's direction.
- R11: A zero-length request is accepted and causes no fetch, no access and no fault.
- R12: While `pte_req_valid` or `acc_valid` is held without the matching ready, the valid stays high and the address and length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled when a request is accepted |
| win_start | input | 32 | Lowest virtual address of the translated window |
| tbl_base | input | 32 | Table base register; shifted left by 4 to give a byte address |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 32 | Start virtual address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| pte_req_valid | output | 1 | Entry fetch request |
| pte_req_ready | input | 1 | Fetch request accepted |
| pte_req_addr | output | 32 | Byte address of the entry |
| pte_rsp_valid | input | 1 | Fetched entry present |
| pte_rsp_data | input | 32 | Fetched entry |
| acc_valid | output | 1 | Physical access piece present |
| acc_ready | input | 1 | Access piece accepted |
| acc_paddr | output | 32 | Physical address of the piece |
| acc_len | output | LEN_W | Byte count of the piece |
| acc_write | output | 1 | Direction of the piece |
| acc_cache | output | 1 | Cacheable attribute from the entry |
| acc_last | output | 1 | Final piece of the transfer |
| fault_valid | output | 1 | One-cycle fault report |
| fault_cause | output | 2 | 2'b01 invalid entry, 2'b10 write to read-only page |
| fault_vaddr | output | 32 | Virtual address whose page faulted |

## Verification
The checks on held fetch and access requests assume that `win_start` and `tbl_base` do not change while a transfer is in progress. The page-span check reads `xlat_en` live, so it also assumes that the enable stays at its accepted value until the block is idle again. The bench changes all three inputs only between transfers, after it has seen `req_ready` return high. It also varies fetch latency and both ready inputs in a fixed rotating pattern, so that the hold checks see stalls.

// File: rtl/iopt_xlate.sv
module iopt_xlate #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlat_en,
  input  logic [31:0]      win_start,
  input  logic [31:0]      tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             pte_req_valid,
  input  logic             pte_req_ready,
  output logic [31:0]      pte_req_addr,
  input  logic             pte_rsp_valid,
  input  logic [31:0]      pte_rsp_data,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic [31:0]      acc_paddr,
  output logic [LEN_W-1:0] acc_len,
  output logic             acc_write,
  output logic             acc_cache,
  output logic             acc_last,
  output logic             fault_valid,
  output logic [1:0]       fault_cause,
  output logic [31:0]      fault_vaddr
);

  localparam int PG_W = 12;
  localparam logic [31:0] PG_SIZE = 32'd1 << PG_W;
  localparam int IDX_SHIFT = PG_W - 2;
  localparam logic [1:0] CAUSE_INVALID = 2'b01;
  localparam logic [1:0] CAUSE_WPROT   = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_FREQ, S_FWAIT, S_CHECK, S_ACC} st_t;

  st_t              st;
  logic [31:0]      cur_va;
  logic [LEN_W-1:0] len_left;
  logic             wr, byp;
  logic [18:0]      ppn;
  logic             ent_v, ent_w, ent_c;

  logic [31:0] win_off, page_room, left32, piece32;
  logic        unused_bits;

  assign win_off      = cur_va - win_start;
  assign pte_req_addr = (tbl_base << 4) + ((win_off >> IDX_SHIFT) & ~32'd3);
  assign page_room    = PG_SIZE - {20'd0, cur_va[PG_W-1:0]};
  assign left32       = 32'(len_left);
  assign piece32      = (byp || left32 < page_room) ? left32 : page_room;

  assign req_ready     = (st == S_IDLE);
  assign pte_req_valid = (st == S_FREQ);
  assign acc_valid     = (st == S_ACC);
  assign acc_len       = piece32[LEN_W-1:0];
  assign acc_last      = (piece32 == left32);
  assign acc_paddr     = byp ? cur_va : {1'b0, ppn, cur_va[PG_W-1:0]};
  assign acc_write     = wr;
  assign acc_cache     = ent_c & ~byp;
  assign unused_bits   = ^{pte_rsp_data[31:27], pte_rsp_data[6:3], pte_rsp_data[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_va      <= '0;
      len_left    <= '0;
      wr          <= 1'b0;
      byp         <= 1'b0;
      ppn         <= '0;
      ent_v       <= 1'b0;
      ent_w       <= 1'b0;
      ent_c       <= 1'b0;
      fault_valid <= 1'b0;
      fault_cause <= '0;
      fault_vaddr <= '0;
    end else begin
      fault_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          cur_va   <= req_vaddr;
          len_left <= req_len;
          wr       <= req_write;
          byp      <= ~xlat_en;
          ent_c    <= 1'b0;
          if (req_len != '0) st <= xlat_en ? S_FREQ : S_ACC;
        end
        S_FREQ: if (pte_req_ready) st <= S_FWAIT;
        S_FWAIT: if (pte_rsp_valid) begin
          ppn   <= pte_rsp_data[26:8];
          ent_c <= pte_rsp_data[7];
          ent_w <= pte_rsp_data[2];
          ent_v <= pte_rsp_data[1];
          st    <= S_CHECK;
        end
        S_CHECK: begin
          if (!ent_v || (wr && !ent_w)) begin
            fault_valid <= 1'b1;
            fault_cause <= !ent_v ? CAUSE_INVALID : CAUSE_WPROT;
            fault_vaddr <= cur_va;
            st          <= S_IDLE;
          end else begin
            st <= S_ACC;
          end
        end
        S_ACC: if (acc_ready) begin
          cur_va   <= cur_va + piece32;
          len_left <= len_left - acc_len;
          st       <= acc_last ? S_IDLE : S_FREQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xlat_en,
  input logic             req_ready,
  input logic             pte_req_valid,
  input logic             pte_req_ready,
  input logic [31:0]      pte_req_addr,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic [31:0]      acc_paddr,
  input logic [LEN_W-1:0] acc_len,
  input logic             fault_valid,
  input logic [1:0]       fault_cause
);

  // R12
  pte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid && !pte_req_ready |=> pte_req_valid && $stable(pte_req_addr));

  // R12
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_paddr) && $stable(acc_len));

  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  // R7
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_cause == 2'b01 || fault_cause == 2'b10));

  // R4
  page_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && xlat_en |-> ({20'd0, acc_paddr[11:0]} + 32'(acc_len)) <= 32'd4096);

  // R1
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, pte_req_valid, acc_valid}));

endmodule

bind iopt_xlate iopt_xlate_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_ready(req_ready),
  .pte_req_valid(pte_req_valid), .pte_req_ready(pte_req_ready),
  .pte_req_addr(pte_req_addr), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_paddr(acc_paddr), .acc_len(acc_len), .fault_valid(fault_valid),
  .fault_cause(fault_cause)
);

// File: tb/iopt_xlate_test.sv
module iopt_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 0, rst_n = 0;
  logic xlat_en = 1;
  logic [31:0] win_start = 32'hFF00_0000, tbl_base = 32'h0001_0000;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [31:0] req_vaddr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic pte_req_valid, pte_req_ready = 0;
  logic [31:0] pte_req_addr;
  logic pte_rsp_valid = 0;
  logic [31:0] pte_rsp_data = 0;
  logic acc_valid, acc_ready = 0, acc_write, acc_cache, acc_last;
  logic [31:0] acc_paddr;
  logic [LEN_W-1:0] acc_len;
  logic fault_valid;
  logic [1:0] fault_cause;
  logic [31:0] fault_vaddr;

  int checks = 0, errors = 0, tick = 0;
  bit done = 0;

  iopt_xlate #(.LEN_W(LEN_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pte_of(logic [31:0] a);
    logic [7:0] i;
    logic [18:0] ppn;
    i = a[9:2];
    ppn = (19'(i) * 19'd37 + 19'd5) ^ 19'h5A5A5;
    return {5'b10110, ppn, i[0], 4'b1010, (i % 3) != 0, (i % 7) != 5, 1'b1};
  endfunction

  // observed traffic
  logic [31:0] g_fa[16];
  logic [31:0] g_pa[16];
  logic [LEN_W-1:0] g_len[16];
  logic g_wr[16], g_c[16], g_last[16];
  int g_nf = 0, g_np = 0, g_nflt = 0;
  logic [1:0] g_cause;
  logic [31:0] g_fva;
  int pend = 0, dly = 0;
  logic [31:0] lat_addr;

  always @(negedge clk) begin
    tick++;
    pte_rsp_valid = 0;
    if (pend != 0) begin
      if (dly == 0) begin
        pte_rsp_valid = 1; pte_rsp_data = pte_of(lat_addr); pend = 0;
      end else dly--;
    end
    pte_req_ready = (tick % 4) != 1;
    acc_ready = (tick % 3) != 2;
    if (pte_req_valid && pte_req_ready) begin
      lat_addr = pte_req_addr; pend = 1; dly = tick % 3;
      if (g_nf < 16) g_fa[g_nf] = pte_req_addr;
      g_nf++;
    end
    if (acc_valid && acc_ready) begin
      if (g_np < 16) begin
        g_pa[g_np] = acc_paddr; g_len[g_np] = acc_len; g_wr[g_np] = acc_write;
        g_c[g_np] = acc_cache; g_last[g_np] = acc_last;
      end
      g_np++;
    end
    if (fault_valid) begin
      g_nflt++; g_cause = fault_cause; g_fva = fault_vaddr;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] va, int len, bit wr, bit en);
    logic [31:0] v, ea, p, pa;
    int left, pl, room, ef, ep, wd;
    bit flt;
    logic [1:0] ecause;
    @(posedge clk); #1;
    g_nf = 0; g_np = 0; g_nflt = 0;
    xlat_en = en; req_vaddr = va; req_len = LEN_W'(len); req_write = wr; req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    wd = 0;
    while (!req_ready && wd < 2000) begin @(posedge clk); #1; wd++; end
    @(negedge clk); #1;
    chk(wd < 2000, "R1 transfer completes", 64'(wd), 0);

    v = va; left = len; ef = 0; ep = 0; flt = 0; ecause = 0;
    if (len != 0 && !en) begin
      chk(g_np == 1 && g_nf == 0, "R9 single access no fetch", 64'(g_np * 100 + g_nf), 100);
      if (g_np == 1) begin
        chk(g_pa[0] == va && g_len[0] == LEN_W'(len) && g_last[0] && !g_c[0] && g_wr[0] == wr,
            "R9 bypass piece", {g_pa[0], 16'(g_len[0]), 16'h0}, {va, 16'(len), 16'h0});
      end
      chk(g_nflt == 0, "R9 no fault", 64'(g_nflt), 0);
      return;
    end
    while (left > 0) begin
      ea = (tbl_base << 4) + (((v - win_start) >> 10) & ~32'd3);
      if (ef < 16 && ef < g_nf)
        chk(g_fa[ef] == ea, "R2 entry address", 64'(g_fa[ef]), 64'(ea));
      ef++;
      p = pte_of(ea);
      if (!p[1]) begin flt = 1; ecause = 2'b01; break; end
      if (wr && !p[2]) begin flt = 1; ecause = 2'b10; break; end
      room = 4096 - int'(v[11:0]);
      pl = (left < room) ? left : room;
      pa = {1'b0, p[26:8], v[11:0]};
      if (ep < g_np && ep < 16) begin
        chk(g_pa[ep] == pa, "R3 physical address", 64'(g_pa[ep]), 64'(pa));
        chk(g_len[ep] == LEN_W'(pl) && g_last[ep] == (pl == left), "R4 piece length/last",
            64'({g_len[ep], g_last[ep]}), 64'({LEN_W'(pl), pl == left}));
        chk(g_c[ep] == p[7] && g_wr[ep] == wr, "R10 attributes",
            64'({g_c[ep], g_wr[ep]}), 64'({p[7], wr}));
      end
      ep++;
      v = v + 32'(pl); left = left - pl;
    end
    chk(g_np == ep, "R4 R12 piece count", 64'(g_np), 64'(ep));
    chk(g_nf == ef, "R5 fetch count", 64'(g_nf), 64'(ef));
    if (len == 0)
      chk(g_nf + g_np + g_nflt == 0, "R11 zero length idle", 64'(g_nf + g_np + g_nflt), 0);
    chk(g_nflt == (flt ? 1 : 0), "R6 fault count", 64'(g_nflt), 64'(flt));
    if (flt && g_nflt == 1) begin
      if (wr && ecause == 2'b01 && !pte_of(ea)[2])
        chk(g_cause == 2'b01, "R8 invalid wins", 64'(g_cause), 1);
      else if (ecause == 2'b01)
        chk(g_cause == 2'b01, "R6 invalid cause", 64'(g_cause), 1);
      else
        chk(g_cause == 2'b10, "R7 write-protect cause", 64'(g_cause), 2);
      chk(g_fva == v, "R6 fault address", 64'(g_fva), 64'(v));
    end
  endtask

  initial begin
    int offs[4];
    int lens[4];
    offs = '{0, 1, 2048, 4095};
    lens = '{1, 4096, 4097, 9000};
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && !pte_req_valid && !acc_valid && !fault_valid, "R1 reset state",
        64'({req_ready, pte_req_valid, acc_valid, fault_valid}), 64'b1000);
    rst_n = 1;
    for (int pg = 0; pg < 14; pg++)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 4; l++)
          for (int w = 0; w < 2; w++)
            run(win_start + 32'(pg * 4096 + offs[o]), lens[l], w[0], 1'b1);
    run(32'hFF00_4000, 0, 1'b0, 1'b1);
    run(32'hFF00_4000, 0, 1'b1, 1'b0);
    for (int b = 0; b < 4; b++)
      run(32'h1234_5000 + 32'(b * 777), lens[b], b[0], 1'b0);
    win_start = 32'hFE00_0000; tbl_base = 32'h0002_3450;
    for (int pg = 0; pg < 20; pg++)
      for (int w = 0; w < 2; w++)
        run(32'hFE80_0000 + 32'(pg * 4096 + 100), 12000, w[0], 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule